// File: doc/BRIEF.md
# Two-Port RAM with Cross-Port Mailbox Interrupts

This block is a two-port synchronous word memory. Both ports run on one shared clock. Each port has its own address, read/write select, a pair of chip enables, four byte enables, a write data bus, a registered read data bus gated by an output enable, and an active-low interrupt output. Either port can read or write any word. Writes are merged one byte lane at a time. Read data appears on the clock edge after the read.

The two highest word addresses act as mailboxes, one owned by each port. The topmost word belongs to the right port and the word just below it belongs to the left port. A port sends a message by writing into the other port's mailbox, which pulls the owner's interrupt low. The owner releases the interrupt by reading its own mailbox. The mailbox words also hold data like any other word, so the message itself can travel in them.

An asynchronous active-low master reset releases both interrupts and clears both read registers. The memory contents are not reset.

Top module: `xport_mbox_ram`

## Requirements
- R1: While `mrst_n` is low, both `l_irq_n` and `r_irq_n` are high and both read data buses are zero. This takes effect without waiting for a clock edge.
- R2: A left-port write to the topmost address with the port selected and at least one byte enable set drives `r_irq_n` low from the next clock edge onward.
- R3: A right-port write to the address one below the top, with the port selected and at least one byte enable set, drives `l_irq_n` low from the next clock edge onward.
- R4: A selected read with at least one byte enable set, made by a port to its own mailbox (right: topmost address, left: one below it), returns that port's interrupt output high after the edge.
- R5: A mailbox write or mailbox read with all four byte enables low neither raises nor releases any interrupt.
- R6: Reading the other port's mailbox does not release that port's interrupt, and writing one's own mailbox does not raise one's own interrupt. Accesses to any non-mailbox address leave both interrupts unchanged.
- R7: A port is selected only when its `*_ce_n` is low and its `*_ce` is high. A deselected port writes nothing, does not update its read data, and neither raises nor releases an interrupt.
- R8: The output enable only gates the read data bus: when `*_oe` is low that bus reads zero. The output enable has no effect on raising or releasing interrupts.
- R9: When, on the same edge, one port raises an interrupt and its owner reads the mailbox to release it, the interrupt stays asserted (low).
- R10: Byte lane k is data bits [9k+8:9k] and is controlled by byte enable bit k. A write changes only the enabled lanes. A read loads the read register on that edge: enabled lanes take the stored value and disabled lanes read zero.
- R11: The mailbox words store and return written data like any other address, and a read returns the contents held before any write made on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock for both ports |
| mrst_n | input | 1 | Asynchronous master reset, active low |
| l_addr | input | ADDR_W | Left word address |
| l_wr | input | 1 | Left select: 1 write, 0 read |
| l_ce_n | input | 1 | Left chip enable, active low |
| l_ce | input | 1 | Left chip enable, active high |
| l_be | input | BE_W | Left byte enables, one per 9-bit lane |
| l_oe | input | 1 | Left output enable for read data |
| l_wdata | input | DATA_W | Left write data |
| l_rdata | output | DATA_W | Left registered read data |
| l_irq_n | output | 1 | Left mailbox interrupt, active low |
| r_addr | input | ADDR_W | Right word address |
| r_wr | input | 1 | Right select: 1 write, 0 read |
| r_ce_n | input | 1 | Right chip enable, active low |
| r_ce | input | 1 | Right chip enable, active high |
| r_be | input | BE_W | Right byte enables, one per 9-bit lane |
| r_oe | input | 1 | Right output enable for read data |
| r_wdata | input | DATA_W | Right write data |
| r_rdata | output | DATA_W | Right registered read data |
| r_irq_n | output | 1 | Right mailbox interrupt, active low |

## Verification
The assertions check the interrupt protocol on every cycle from the port pins alone. A qualified cross-port mailbox write always lowers the owner's line, and set wins over a same-edge release. A qualified owner read always raises the line. Any cycle with neither event leaves the line where it was, which covers the byte-enable, chip-enable and non-owner cases. The assertions also check reset and output-enable gating. Stored data can only be shown by the bench's scenarios, which run against a shadow model: partial-lane merges, zeroed lanes on partial reads, read-before-write when both ports touch the same word, mailbox words carrying data, and read data holding while a port is deselected.

// File: rtl/mbx_pkg.sv
// Shared definitions for the two-port mailbox RAM.
// Assumes the mailbox words sit at the top of the address space:
// the right port owns offset 0 below the top, the left port offset 1.
package mbx_pkg;

    localparam int LANE_BITS = 9;

    typedef enum logic {
        PORT_LEFT  = 1'b0,
        PORT_RIGHT = 1'b1
    } port_id_e;

    // Distance of a port's own mailbox below the topmost word.
    function automatic int mbox_offset(port_id_e pid);
        return (pid == PORT_RIGHT) ? 0 : 1;
    endfunction

    // The port on the other side.
    function automatic port_id_e peer_of(port_id_e pid);
        return (pid == PORT_RIGHT) ? PORT_LEFT : PORT_RIGHT;
    endfunction

endpackage

// File: rtl/mbx_port_dec.sv
// Per-port access decoder.
// Combines the two chip enables, turns the port controls into memory
// write/read strobes, and spots the two mailbox events: a write to the
// peer's mailbox and a read of the port's own mailbox. Both events
// need at least one byte enable. Purely combinational.
module mbx_port_dec
    import mbx_pkg::*;
#(
    parameter int       ADDR_W = 6,
    parameter int       BE_W   = 4,
    parameter port_id_e PID    = PORT_LEFT
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic              ce_n,
    input  logic              ce,
    input  logic [BE_W-1:0]   be,
    output logic              mem_we,
    output logic              mem_re,
    output logic              set_peer,
    output logic              clr_own
);

    localparam logic [ADDR_W-1:0] TOP_ADDR  = '1;
    localparam logic [ADDR_W-1:0] OWN_ADDR  = TOP_ADDR - ADDR_W'(mbox_offset(PID));
    localparam logic [ADDR_W-1:0] PEER_ADDR = TOP_ADDR - ADDR_W'(mbox_offset(peer_of(PID)));

    logic sel;
    logic live;

    // Decode strobes and mailbox events from this port's controls.
    always_comb begin
        sel      = !ce_n && ce;
        live     = sel && (|be);
        mem_we   = sel && wr;
        mem_re   = sel && !wr;
        set_peer = live && wr && (addr == PEER_ADDR);
        clr_own  = live && !wr && (addr == OWN_ADDR);
    end

endmodule

// File: rtl/mbx_ram.sv
// Byte-lane two-port memory on a single clock.
// Each lane is its own array so the byte enables gate writes per lane.
// If both ports write the same word on one edge, the right port's
// lanes land last. Reads capture the contents held before the edge.
// A disabled lane reads zero. The read registers clear on reset;
// the arrays do not.
module mbx_ram #(
    parameter int ADDR_W = 6,
    parameter int BE_W   = 4,
    parameter int LANE_W = 9,
    localparam int DATA_W = BE_W * LANE_W,
    localparam int DEPTH  = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              mrst_n,
    input  logic              a_we,
    input  logic              a_re,
    input  logic [ADDR_W-1:0] a_addr,
    input  logic [BE_W-1:0]   a_be,
    input  logic [DATA_W-1:0] a_wd,
    output logic [DATA_W-1:0] a_rq,
    input  logic              b_we,
    input  logic              b_re,
    input  logic [ADDR_W-1:0] b_addr,
    input  logic [BE_W-1:0]   b_be,
    input  logic [DATA_W-1:0] b_wd,
    output logic [DATA_W-1:0] b_rq
);

    for (genvar k = 0; k < BE_W; k++) begin : g_lane
        logic [LANE_W-1:0] cells [DEPTH];

        // Store enabled lanes from either port; port b is applied last.
        always_ff @(posedge clk) begin
            if (a_we && a_be[k]) cells[a_addr] <= a_wd[k*LANE_W +: LANE_W];
            if (b_we && b_be[k]) cells[b_addr] <= b_wd[k*LANE_W +: LANE_W];
        end

        // Capture this lane for each reading port, zero when disabled.
        always_ff @(posedge clk or negedge mrst_n) begin
            if (!mrst_n) begin
                a_rq[k*LANE_W +: LANE_W] <= '0;
                b_rq[k*LANE_W +: LANE_W] <= '0;
            end else begin
                if (a_re) a_rq[k*LANE_W +: LANE_W] <= a_be[k] ? cells[a_addr] : '0;
                if (b_re) b_rq[k*LANE_W +: LANE_W] <= b_be[k] ? cells[b_addr] : '0;
            end
        end
    end

endmodule

// File: rtl/mbx_flag.sv
// One mailbox interrupt flag.
// Raised by the peer's mailbox write, released by the owner's read;
// a raise on the same edge as a release wins. Cleared asynchronously
// by master reset. The output is active low.
module mbx_flag (
    input  logic clk,
    input  logic mrst_n,
    input  logic raise,
    input  logic release_req,
    output logic irq_n
);

    logic pending;

    // Hold the pending message state; raise has priority.
    always_ff @(posedge clk or negedge mrst_n) begin
        if (!mrst_n)          pending <= 1'b0;
        else if (raise)       pending <= 1'b1;
        else if (release_req) pending <= 1'b0;
    end

    assign irq_n = ~pending;

endmodule

// File: rtl/xport_mbox_ram.sv
// Two-port synchronous RAM with a cross-port mailbox interrupt per port.
// The topmost word is the right port's mailbox and the word below it is
// the left port's. Both ports share one clock. Read data is registered
// and gated to zero by each port's output enable. Master reset is
// asynchronous, active low.
module xport_mbox_ram
    import mbx_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int BE_W   = 4,
    localparam int DATA_W = BE_W * LANE_BITS
) (
    input  logic              clk,
    input  logic              mrst_n,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic              l_wr,
    input  logic              l_ce_n,
    input  logic              l_ce,
    input  logic [BE_W-1:0]   l_be,
    input  logic              l_oe,
    input  logic [DATA_W-1:0] l_wdata,
    output logic [DATA_W-1:0] l_rdata,
    output logic              l_irq_n,
    input  logic [ADDR_W-1:0] r_addr,
    input  logic              r_wr,
    input  logic              r_ce_n,
    input  logic              r_ce,
    input  logic [BE_W-1:0]   r_be,
    input  logic              r_oe,
    input  logic [DATA_W-1:0] r_wdata,
    output logic [DATA_W-1:0] r_rdata,
    output logic              r_irq_n
);

    logic l_we, l_re, l_set_r, l_clr_l;
    logic r_we, r_re, r_set_l, r_clr_r;
    logic [DATA_W-1:0] l_rq, r_rq;

    mbx_port_dec #(.ADDR_W(ADDR_W), .BE_W(BE_W), .PID(PORT_LEFT)) u_dec_l (
        .addr(l_addr), .wr(l_wr), .ce_n(l_ce_n), .ce(l_ce), .be(l_be),
        .mem_we(l_we), .mem_re(l_re), .set_peer(l_set_r), .clr_own(l_clr_l)
    );

    mbx_port_dec #(.ADDR_W(ADDR_W), .BE_W(BE_W), .PID(PORT_RIGHT)) u_dec_r (
        .addr(r_addr), .wr(r_wr), .ce_n(r_ce_n), .ce(r_ce), .be(r_be),
        .mem_we(r_we), .mem_re(r_re), .set_peer(r_set_l), .clr_own(r_clr_r)
    );

    mbx_ram #(.ADDR_W(ADDR_W), .BE_W(BE_W), .LANE_W(LANE_BITS)) u_ram (
        .clk(clk), .mrst_n(mrst_n),
        .a_we(l_we), .a_re(l_re), .a_addr(l_addr), .a_be(l_be), .a_wd(l_wdata), .a_rq(l_rq),
        .b_we(r_we), .b_re(r_re), .b_addr(r_addr), .b_be(r_be), .b_wd(r_wdata), .b_rq(r_rq)
    );

    mbx_flag u_flag_l (
        .clk(clk), .mrst_n(mrst_n), .raise(r_set_l), .release_req(l_clr_l), .irq_n(l_irq_n)
    );

    mbx_flag u_flag_r (
        .clk(clk), .mrst_n(mrst_n), .raise(l_set_r), .release_req(r_clr_r), .irq_n(r_irq_n)
    );

    // Gate registered read data with each port's output enable.
    always_comb begin
        l_rdata = l_oe ? l_rq : '0;
        r_rdata = r_oe ? r_rq : '0;
    end

endmodule

// File: rtl/mbx_chk.sv
// Protocol checker for xport_mbox_ram, observing its ports only.
// Recomputes the mailbox events from the pins and checks the
// interrupt lines, reset state and output-enable gating.
module mbx_chk #(
    parameter int ADDR_W = 6,
    parameter int BE_W   = 4,
    parameter int DATA_W = 36
) (
    input logic              clk,
    input logic              mrst_n,
    input logic [ADDR_W-1:0] l_addr,
    input logic              l_wr,
    input logic              l_ce_n,
    input logic              l_ce,
    input logic [BE_W-1:0]   l_be,
    input logic              l_oe,
    input logic [DATA_W-1:0] l_rdata,
    input logic              l_irq_n,
    input logic [ADDR_W-1:0] r_addr,
    input logic              r_wr,
    input logic              r_ce_n,
    input logic              r_ce,
    input logic [BE_W-1:0]   r_be,
    input logic              r_oe,
    input logic [DATA_W-1:0] r_rdata,
    input logic              r_irq_n
);

    localparam logic [ADDR_W-1:0] TOP = '1;
    localparam logic [ADDR_W-1:0] NXT = TOP - 1'b1;

    logic l_go, r_go, to_r, to_l, rel_r, rel_l;

    // Pin-level view of the mailbox events.
    always_comb begin
        l_go  = !l_ce_n && l_ce && (|l_be);
        r_go  = !r_ce_n && r_ce && (|r_be);
        to_r  = l_go && l_wr && (l_addr == TOP);
        to_l  = r_go && r_wr && (r_addr == NXT);
        rel_r = r_go && !r_wr && (r_addr == TOP);
        rel_l = l_go && !l_wr && (l_addr == NXT);
    end

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        !mrst_n |-> (l_irq_n && r_irq_n && l_rdata == '0 && r_rdata == '0));

    // R2, R9
    raise_r_chk: assert property (@(posedge clk) disable iff (!mrst_n)
        to_r |=> !r_irq_n);

    // R3, R9
    raise_l_chk: assert property (@(posedge clk) disable iff (!mrst_n)
        to_l |=> !l_irq_n);

    // R4
    release_r_chk: assert property (@(posedge clk) disable iff (!mrst_n)
        (rel_r && !to_r) |=> r_irq_n);

    // R4
    release_l_chk: assert property (@(posedge clk) disable iff (!mrst_n)
        (rel_l && !to_l) |=> l_irq_n);

    // R6
    hold_r_chk: assert property (@(posedge clk) disable iff (!mrst_n)
        (!to_r && !rel_r) |=> $stable(r_irq_n));

    // R6
    hold_l_chk: assert property (@(posedge clk) disable iff (!mrst_n)
        (!to_l && !rel_l) |=> $stable(l_irq_n));

    // R8
    oe_gate_chk: assert property (@(posedge clk) disable iff (!mrst_n)
        ((!l_oe -> l_rdata == '0) && (!r_oe -> r_rdata == '0)));

endmodule

bind xport_mbox_ram mbx_chk #(.ADDR_W(ADDR_W), .BE_W(BE_W), .DATA_W(DATA_W)) u_chk (
    .clk(clk), .mrst_n(mrst_n),
    .l_addr(l_addr), .l_wr(l_wr), .l_ce_n(l_ce_n), .l_ce(l_ce), .l_be(l_be),
    .l_oe(l_oe), .l_rdata(l_rdata), .l_irq_n(l_irq_n),
    .r_addr(r_addr), .r_wr(r_wr), .r_ce_n(r_ce_n), .r_ce(r_ce), .r_be(r_be),
    .r_oe(r_oe), .r_rdata(r_rdata), .r_irq_n(r_irq_n)
);

// File: tb/xport_mbox_ram_tb.sv
// Scoreboard bench: the driver applies one operation per port per cycle,
// updates a shadow model and queues the expected outputs; the monitor
// pops one item after each clock edge and compares.
module xport_mbox_ram_tb;

    localparam int CLK_PERIOD = 10;
    localparam int AW  = 6;
    localparam int BW  = 4;
    localparam int LW  = 9;
    localparam int DW  = BW * LW;
    localparam int DEP = 1 << AW;
    localparam logic [AW-1:0] TOP = '1;
    localparam logic [AW-1:0] NXT = TOP - 1'b1;

    typedef struct packed {
        logic          ce_n;
        logic          ce;
        logic          wr;
        logic [BW-1:0] be;
        logic [AW-1:0] addr;
        logic [DW-1:0] wd;
        logic          oe;
    } op_t;

    typedef struct {
        string         tag;
        logic          l_irq;
        logic          r_irq;
        logic [DW-1:0] l_rd;
        logic [DW-1:0] r_rd;
    } exp_t;

    logic clk = 1'b0;
    logic mrst_n = 1'b0;
    op_t  lo, ro;
    logic [DW-1:0] l_rdata, r_rdata;
    logic l_irq_n, r_irq_n;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    exp_t sb[$];

    logic [DW-1:0] shadow [DEP];
    logic [DW-1:0] m_lrq = '0, m_rrq = '0;
    bit m_fl_l = 1'b0, m_fl_r = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    xport_mbox_ram #(.ADDR_W(AW), .BE_W(BW)) u_dut (
        .clk(clk), .mrst_n(mrst_n),
        .l_addr(lo.addr), .l_wr(lo.wr), .l_ce_n(lo.ce_n), .l_ce(lo.ce), .l_be(lo.be),
        .l_oe(lo.oe), .l_wdata(lo.wd), .l_rdata(l_rdata), .l_irq_n(l_irq_n),
        .r_addr(ro.addr), .r_wr(ro.wr), .r_ce_n(ro.ce_n), .r_ce(ro.ce), .r_be(ro.be),
        .r_oe(ro.oe), .r_wdata(ro.wd), .r_rdata(r_rdata), .r_irq_n(r_irq_n)
    );

    function automatic op_t idle();
        op_t o;
        o = '0;
        o.ce_n = 1'b1;
        o.oe = 1'b1;
        return o;
    endfunction

    function automatic op_t wrop(logic [AW-1:0] a, logic [BW-1:0] be, logic [DW-1:0] d);
        op_t o;
        o = idle();
        o.ce_n = 1'b0; o.ce = 1'b1; o.wr = 1'b1; o.be = be; o.addr = a; o.wd = d;
        return o;
    endfunction

    function automatic op_t rdop(logic [AW-1:0] a, logic [BW-1:0] be);
        op_t o;
        o = idle();
        o.ce_n = 1'b0; o.ce = 1'b1; o.be = be; o.addr = a;
        return o;
    endfunction

    function automatic logic [DW-1:0] lanes(logic [DW-1:0] w, logic [BW-1:0] be);
        logic [DW-1:0] r;
        r = '0;
        for (int k = 0; k < BW; k++) if (be[k]) r[k*LW +: LW] = w[k*LW +: LW];
        return r;
    endfunction

    task automatic check(string tag, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Drive one cycle on both ports, advance the shadow model, queue expectations.
    task automatic step(op_t l, op_t r, string tag);
        bit lsel, rsel, l_raise_r, r_raise_l, l_rel, r_rel;
        exp_t e;
        @(negedge clk);
        lo = l; ro = r;
        lsel = !l.ce_n && l.ce;
        rsel = !r.ce_n && r.ce;
        if (lsel && !l.wr) m_lrq = lanes(shadow[l.addr], l.be);
        if (rsel && !r.wr) m_rrq = lanes(shadow[r.addr], r.be);
        for (int k = 0; k < BW; k++) begin
            if (lsel && l.wr && l.be[k]) shadow[l.addr][k*LW +: LW] = l.wd[k*LW +: LW];
            if (rsel && r.wr && r.be[k]) shadow[r.addr][k*LW +: LW] = r.wd[k*LW +: LW];
        end
        l_raise_r = lsel && (|l.be) && l.wr && l.addr == TOP;
        r_raise_l = rsel && (|r.be) && r.wr && r.addr == NXT;
        r_rel     = rsel && (|r.be) && !r.wr && r.addr == TOP;
        l_rel     = lsel && (|l.be) && !l.wr && l.addr == NXT;
        m_fl_r = l_raise_r ? 1'b1 : (r_rel ? 1'b0 : m_fl_r);
        m_fl_l = r_raise_l ? 1'b1 : (l_rel ? 1'b0 : m_fl_l);
        e.tag   = tag;
        e.l_irq = ~m_fl_l;
        e.r_irq = ~m_fl_r;
        e.l_rd  = l.oe ? m_lrq : '0;
        e.r_rd  = r.oe ? m_rrq : '0;
        sb.push_back(e);
    endtask

    // Monitor: compare one queued item just after each rising edge.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                check(e.tag, "l_irq_n", DW'(l_irq_n), DW'(e.l_irq));
                check(e.tag, "r_irq_n", DW'(r_irq_n), DW'(e.r_irq));
                check(e.tag, "l_rdata", l_rdata, e.l_rd);
                check(e.tag, "r_rdata", r_rdata, e.r_rd);
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    // Watchdog.
    initial begin
        #(CLK_PERIOD * 5000);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        op_t o;
        lo = idle(); ro = idle();
        for (int i = 0; i < DEP; i++) shadow[i] = '0;
        #3;
        // R1: reset state before the first edge
        check("R1", "l_irq_n in reset", DW'(l_irq_n), DW'(1'b1));
        check("R1", "r_irq_n in reset", DW'(r_irq_n), DW'(1'b1));
        check("R1", "l_rdata in reset", l_rdata, '0);
        repeat (2) @(negedge clk);
        mrst_n = 1'b1;

        // R10: full write, cross read, partial merge, partial read
        step(wrop(6'd5, 4'hF, 36'h1_2345_6789), idle(), "R10");
        step(idle(), rdop(6'd5, 4'hF), "R10");
        step(wrop(6'd5, 4'b0101, 36'hF_FFFF_FFFF), idle(), "R10");
        step(rdop(6'd5, 4'hF), rdop(6'd5, 4'b0011), "R10");
        step(idle(), idle(), "R10");

        // R2, R11: left posts to right mailbox with data
        step(wrop(TOP, 4'hF, 36'hA_BCDE_F012), idle(), "R2");
        // R6: non-owner read keeps flag, data returned (R11)
        step(rdop(TOP, 4'hF), idle(), "R6");
        // R6: other-address traffic leaves flags
        step(wrop(6'd9, 4'hF, 36'h0_0000_0009), rdop(6'd5, 4'hF), "R6");
        // R5: owner read with no byte enables does not release
        step(idle(), rdop(TOP, 4'h0), "R5");
        // R7: deselected owner read does not release, rdata holds
        o = rdop(TOP, 4'hF); o.ce = 1'b0;
        step(idle(), o, "R7");
        // R8: owner read with oe low still releases, bus reads zero
        o = rdop(TOP, 4'hF); o.oe = 1'b0;
        step(idle(), o, "R8");
        step(idle(), idle(), "R8");
        // R11: mailbox word returns stored data
        step(idle(), rdop(TOP, 4'hF), "R11");

        // R6: right writes its own mailbox, no interrupt
        step(idle(), wrop(TOP, 4'hF, 36'h3_3333_3333), "R6");
        // R3: right posts to left mailbox
        step(idle(), wrop(NXT, 4'b1000, 36'h5_5555_5555), "R3");
        // R6: right reads left mailbox, no release; left writes own, no change
        step(wrop(NXT, 4'b0001, 36'h0_0000_0077), rdop(NXT, 4'hF), "R6");
        // R4: left owner read releases
        step(rdop(NXT, 4'hF), idle(), "R4");

        // R7: left write to top with each enable inactive
        o = wrop(TOP, 4'hF, 36'hD_EAD0_BEEF); o.ce_n = 1'b1;
        step(o, idle(), "R7");
        o = wrop(TOP, 4'hF, 36'hD_EAD0_BEEF); o.ce = 1'b0;
        step(o, rdop(TOP, 4'hF), "R7");
        // R5: mailbox write with no byte enables does not raise
        step(wrop(TOP, 4'h0, 36'h1_1111_1111), idle(), "R5");

        // R9: raise and owner release on the same edge, raise wins
        step(wrop(TOP, 4'b0010, 36'h2_2222_2222), idle(), "R9");
        step(wrop(TOP, 4'hF, 36'h4_4444_4444), rdop(TOP, 4'hF), "R9");
        step(idle(), rdop(TOP, 4'hF), "R4");
        step(wrop(NXT, 4'hF, 36'h6_6666_6666), wrop(NXT, 4'hF, 36'h7_7777_7777), "R9");
        o = rdop(NXT, 4'hF); o.oe = 1'b0;
        step(o, wrop(NXT, 4'b0100, 36'h8_8888_8888), "R9");
        step(rdop(NXT, 4'hF), idle(), "R4");

        // R1: asynchronous reset mid-run with both flags raised
        step(wrop(TOP, 4'hF, 36'h9_9999_9999), wrop(NXT, 4'hF, 36'hA_AAAA_AAAA), "R2");
        step(rdop(6'd9, 4'hF), rdop(6'd5, 4'hF), "R3");
        wait (sb.size() == 0);
        @(posedge clk);
        #4;
        mrst_n = 1'b0;
        #1;
        check("R1", "l_irq_n after async reset", DW'(l_irq_n), DW'(1'b1));
        check("R1", "r_irq_n after async reset", DW'(r_irq_n), DW'(1'b1));
        check("R1", "r_rdata after async reset", r_rdata, '0);
        m_fl_l = 1'b0; m_fl_r = 1'b0; m_lrq = '0; m_rrq = '0;
        @(negedge clk);
        mrst_n = 1'b1;
        // R11: contents survive reset
        step(rdop(TOP, 4'hF), rdop(NXT, 4'hF), "R11");
        step(idle(), idle(), "R1");
        wait (sb.size() == 0);
        @(negedge clk);
        finish_run();
    end

endmodule